// File: doc/BRIEF.md
# Delay Code Sweep and Centring Controller

This block calibrates the input delay of a reference clock that sets the phase of a slave converter's data clock. After a start pulse it steps a delay code upward from zero to the largest useful code, one code at a time. At each code it waits a fixed settling time and then watches a stability flag from an external detector for a set number of cycles. A code is counted as good only if the flag stays high for the whole observation window.

While the sweep runs, the controller keeps only run-length bookkeeping: the current stable run, the best run found so far, and a count of unstable regions. It never stores a table of results per code. At the end it picks one final code. If no unstable region was seen, it uses the centre of the range. Otherwise it uses the centre of the longest stable region, and a tie goes to the region with the lowest codes. It then reports the choice and the count of unstable regions with a one-cycle done pulse.

Top module: `dly_sweep_ctrl`

## Requirements
- R1: The delay code is CODE_W bits wide, where CODE_W is 10 (top code 639) or 9 (top code 319). After start it begins at 0, rises by exactly 1 per judged code, never exceeds the top code, and the sweep ends at the top code.
- R2: Each code is judged only after SETTLE_CYC settling cycles, over SAMPLES consecutive flag samples (default 8). A single low sample marks the code unstable, so a code whose flag flickers at a border counts as unstable.
- R3: When the sweep finds no unstable code, the chosen code is the top code divided by two, rounded down (319 for 10 bits), and the reported region count is 0.
- R4: With exactly one unstable region, the chosen code is the centre of the longest stable region.
- R5: With two or more unstable regions, the chosen code is the centre of the longest stable region. Among stable regions of equal length, the one with the lowest codes wins.
- R6: The centre of a stable region is the rounded-down average of its two bounding codes. Inside the range, a bound is the adjacent unstable code. A region that touches code 0 or the top code is bounded by that end code.
- R7: The reported region count is the number of maximal runs of consecutive unstable codes in the sweep.
- R8: done is high for exactly one cycle per sweep. The chosen code and region count change only in that cycle and hold afterwards. A start pulse during a sweep is ignored and does not restart the code.
- R9: If every code is unstable, the chosen code is the range centre (319 for 10 bits) and the count is 1.
- R10: After reset, the delay code, done, the chosen code and the region count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a sweep when idle |
| stable_in | input | 1 | Stability flag of the observed slave data clock |
| delay_code | output | CODE_W | Delay code currently applied to the reference clock |
| done | output | 1 | One-cycle pulse when a result is ready |
| chosen_code | output | CODE_W | Selected centre code, held until the next result |
| unstable_regions | output | CODE_W | Number of unstable regions found by the last sweep |

## Verification
The bench targets these cases:
- **Two equally long stable regions.** A design that breaks ties the wrong way lands in the upper region, far from the expected code.
- **A stable region touching code 0 or the top code.** A design that takes the bound as the outside neighbour misses the centre by half a code or more.
- **Border codes whose flag flickers between high and low.** A controller that samples too little or too late counts such a code as stable, which widens the region and shifts both the centre and the count.
- **Sweeps that are entirely stable or entirely unstable.** These check the fallback to the range centre.
- **A start pulse in the middle of a sweep.** A design that does not ignore it restarts the code at 0.

// File: rtl/dly_sweep_pkg.sv
package dly_sweep_pkg;
   typedef enum logic [1:0] {
      JP_IDLE,
      JP_SETTLE,
      JP_SAMPLE
   } judge_ph_t;

   typedef enum logic [1:0] {
      TS_IDLE,
      TS_RUN,
      TS_FIN
   } top_st_t;

   function automatic int top_code_for(input int code_w);
      return (code_w == 10) ? 639 : 319;
   endfunction
endpackage

// File: rtl/dly_code_judge.sv
module dly_code_judge
   import dly_sweep_pkg::*;
#(
   parameter int SETTLE_CYC = 4,
   parameter int SAMPLES    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic stable_in,
   output logic verdict_vld,
   output logic verdict_ok
);
   localparam int LIM_MAX = (SETTLE_CYC > SAMPLES) ? SETTLE_CYC : SAMPLES;
   localparam int CNT_W   = $clog2(LIM_MAX + 1);
   localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLES - 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (SAMPLES < 1) begin : g_bad_samples
         $error("SAMPLES must be at least 1");
      end
   endgenerate

   judge_ph_t        ph;
   logic [CNT_W-1:0] cnt;
   logic             acc;
   logic             smp_last;

   generate
      if (SAMPLES == 1) begin : g_single
         assign smp_last = 1'b1;
      end else begin : g_multi
         assign smp_last = (cnt == SMP_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph          <= JP_IDLE;
         cnt         <= '0;
         acc         <= 1'b0;
         verdict_vld <= 1'b0;
         verdict_ok  <= 1'b0;
      end else begin
         verdict_vld <= 1'b0;
         if (go) begin
            ph  <= JP_SETTLE;
            cnt <= '0;
            acc <= 1'b1;
         end else begin
            case (ph)
               JP_SETTLE: begin
                  if (cnt == SET_LAST) begin
                     ph  <= JP_SAMPLE;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               JP_SAMPLE: begin
                  acc <= acc & stable_in;
                  if (smp_last) begin
                     verdict_vld <= 1'b1;
                     verdict_ok  <= acc & stable_in;
                     ph          <= JP_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2: a verdict is a single-cycle event
   p_verdict_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_vld |=> !verdict_vld);

   // R2: a verdict only follows the sampling phase
   p_verdict_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(verdict_vld) |-> $past(ph) == JP_SAMPLE);
endmodule

// File: rtl/dly_run_tracker.sv
module dly_run_tracker #(
   parameter int CODE_W   = 10,
   parameter int TOP_CODE = 639
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              upd,
   input  logic [CODE_W-1:0] code,
   input  logic              is_ok,
   output logic [CODE_W-1:0] regions,
   output logic              has_best,
   output logic [CODE_W-1:0] best_mid
);
   localparam logic [CODE_W-1:0] TOP = CODE_W'(TOP_CODE);

   logic              in_run;
   logic              prev_bad;
   logic [CODE_W-1:0] run_start;
   logic [CODE_W-1:0] cur_len;
   logic [CODE_W-1:0] best_len;

   logic              closing;
   logic [CODE_W-1:0] c_start, c_len, c_lo, c_hi, c_mid;
   logic [CODE_W:0]   c_sum;

   always_comb begin
      closing = upd && ((in_run && !is_ok) || (is_ok && code == TOP));
      c_start = (is_ok && !in_run) ? code : run_start;
      if (is_ok) c_len = in_run ? cur_len + 1'b1 : CODE_W'(1);
      else       c_len = cur_len;
      c_hi    = is_ok ? TOP : code;
      c_lo    = (c_start == '0) ? '0 : c_start - 1'b1;
      c_sum   = {1'b0, c_lo} + {1'b0, c_hi};
      c_mid   = c_sum[CODE_W:1];
   end

   assign has_best = (best_len != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_run    <= 1'b0;
         prev_bad  <= 1'b0;
         run_start <= '0;
         cur_len   <= '0;
         best_len  <= '0;
         best_mid  <= '0;
         regions   <= '0;
      end else if (clear) begin
         in_run    <= 1'b0;
         prev_bad  <= 1'b0;
         run_start <= '0;
         cur_len   <= '0;
         best_len  <= '0;
         best_mid  <= '0;
         regions   <= '0;
      end else if (upd) begin
         if (is_ok) begin
            in_run   <= 1'b1;
            prev_bad <= 1'b0;
            cur_len  <= c_len;
            if (!in_run) run_start <= code;
         end else begin
            in_run   <= 1'b0;
            prev_bad <= 1'b1;
            if (!prev_bad) regions <= regions + 1'b1;
         end
         if (closing && (c_len > best_len)) begin
            best_len <= c_len;
            best_mid <= c_mid;
         end
      end
   end

   // R7: the region count only steps by one or clears
   p_region_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (regions != $past(regions)) |-> (regions == '0 || regions == $past(regions) + 1'b1));

   // R5: the best run never shrinks within a sweep (strictly longer wins, so ties keep the lower run)
   p_best_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> best_len >= $past(best_len));
endmodule

// File: rtl/dly_sweep_ctrl.sv
module dly_sweep_ctrl
   import dly_sweep_pkg::*;
#(
   parameter int CODE_W     = 10,
   parameter int SETTLE_CYC = 4,
   parameter int SAMPLES    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stable_in,
   output logic [CODE_W-1:0] delay_code,
   output logic              done,
   output logic [CODE_W-1:0] chosen_code,
   output logic [CODE_W-1:0] unstable_regions
);
   localparam int                TOP_INT  = top_code_for(CODE_W);
   localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(TOP_INT);
   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(TOP_INT / 2);

   generate
      if (CODE_W != 9 && CODE_W != 10) begin : g_bad_width
         $error("CODE_W must be 9 or 10");
      end
   endgenerate

   top_st_t           st;
   logic              go, clr;
   logic              vld, ok;
   logic [CODE_W-1:0] trk_regions, trk_mid;
   logic              trk_has;
   logic [CODE_W-1:0] pick;

   dly_code_judge #(
      .SETTLE_CYC(SETTLE_CYC),
      .SAMPLES   (SAMPLES)
   ) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .stable_in  (stable_in),
      .verdict_vld(vld),
      .verdict_ok (ok)
   );

   dly_run_tracker #(
      .CODE_W  (CODE_W),
      .TOP_CODE(TOP_INT)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clr),
      .upd     (vld),
      .code    (delay_code),
      .is_ok   (ok),
      .regions (trk_regions),
      .has_best(trk_has),
      .best_mid(trk_mid)
   );

   always_comb begin
      if (trk_regions == '0)  pick = MID_CODE;
      else if (!trk_has)      pick = MID_CODE;
      else                    pick = trk_mid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st               <= TS_IDLE;
         delay_code       <= '0;
         go               <= 1'b0;
         clr              <= 1'b0;
         done             <= 1'b0;
         chosen_code      <= '0;
         unstable_regions <= '0;
      end else begin
         go   <= 1'b0;
         clr  <= 1'b0;
         done <= 1'b0;
         case (st)
            TS_IDLE: begin
               if (start) begin
                  delay_code <= '0;
                  go         <= 1'b1;
                  clr        <= 1'b1;
                  st         <= TS_RUN;
               end
            end
            TS_RUN: begin
               if (vld) begin
                  if (delay_code == TOP_CODE) begin
                     st <= TS_FIN;
                  end else begin
                     delay_code <= delay_code + 1'b1;
                     go         <= 1'b1;
                  end
               end
            end
            TS_FIN: begin
               done             <= 1'b1;
               chosen_code      <= pick;
               unstable_regions <= trk_regions;
               st               <= TS_IDLE;
            end
            default: st <= TS_IDLE;
         endcase
      end
   end

   // R1: the code never passes the top code
   p_code_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      delay_code <= TOP_CODE);

   // R1: the code only restarts at zero or climbs by one
   p_code_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (delay_code != $past(delay_code)) |->
         (delay_code == '0 || delay_code == $past(delay_code) + 1'b1));

   // R8: done lasts one cycle
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: results hold outside the done cycle
   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(chosen_code) && $stable(unstable_regions)));

   // R3: a clean sweep lands on the range centre
   p_clean_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && unstable_regions == '0) |-> chosen_code == MID_CODE);
endmodule

// File: tb/dly_sweep_ctrl_test.sv
module dly_sweep_ctrl_test;
   localparam int CODE_W = 10;
   localparam int TOPC   = 639;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              stable_in = 1'b0;
   logic [CODE_W-1:0] delay_code;
   logic              done;
   logic [CODE_W-1:0] chosen_code;
   logic [CODE_W-1:0] unstable_regions;

   int  n_chk = 0;
   int  n_bad = 0;
   int  cyc = 0;
   bit  stab [0:TOPC];
   bit  inter[0:TOPC];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dly_sweep_ctrl #(.CODE_W(CODE_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .stable_in(stable_in),
      .delay_code(delay_code), .done(done), .chosen_code(chosen_code),
      .unstable_regions(unstable_regions)
   );

   // flag model: flickering codes are forced low every fourth cycle
   always @(negedge clk) begin
      if (inter[delay_code]) stable_in <= ((cyc % 4) != 0) && ($urandom % 2 == 1);
      else                   stable_in <= stab[delay_code];
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit eff(input int c);
      return stab[c] && !inter[c];
   endfunction

   function automatic void close_run(input int s, input int e,
                                     inout int best_len, inout int best_mid);
      int lo, hi;
      lo = (s == 0) ? 0 : s - 1;
      hi = (e == TOPC) ? TOPC : e + 1;
      if (e - s + 1 > best_len) begin
         best_len = e - s + 1;
         best_mid = (lo + hi) / 2;
      end
   endfunction

   function automatic void expect_result(output int pick, output int nreg);
      int best_len, best_mid, run_s;
      best_len = 0; best_mid = 0; run_s = -1; nreg = 0;
      for (int c = 0; c <= TOPC; c++) begin
         if (eff(c)) begin
            if (run_s < 0) run_s = c;
         end else begin
            if (c == 0 || eff(c - 1)) nreg++;
            if (run_s >= 0) begin
               close_run(run_s, c - 1, best_len, best_mid);
               run_s = -1;
            end
         end
      end
      if (run_s >= 0) close_run(run_s, TOPC, best_len, best_mid);
      pick = (nreg == 0 || best_len == 0) ? TOPC / 2 : best_mid;
   endfunction

   task automatic fill(input bit v);
      for (int c = 0; c <= TOPC; c++) begin
         stab[c] = v;
         inter[c] = 1'b0;
      end
   endtask

   task automatic mark_bad(input int lo, input int hi);
      for (int c = lo; c <= hi; c++) if (c >= 0 && c <= TOPC) stab[c] = 1'b0;
   endtask

   task automatic sweep(input string req, input bit poke);
      int  pick, nreg, prev, top_seen, steps_bad, c0;
      bit  got;
      expect_result(pick, nreg);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      prev = 0; top_seen = 0; steps_bad = 0; got = 1'b0;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (int'(delay_code) != prev && int'(delay_code) != prev + 1) steps_bad++;
         prev = int'(delay_code);
         if (prev > top_seen) top_seen = prev;
         if (poke && k == 200) begin
            c0 = int'(delay_code);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            check("R8 start ignored mid-sweep", int'(delay_code >= c0), 1);
            prev = int'(delay_code);
         end
         if (done) begin
            got = 1'b1;
            break;
         end
      end
      check({req, " done seen"}, int'(got), 1);
      check({req, " chosen code"}, int'(chosen_code), pick);
      check({req, " R7 region count"}, int'(unstable_regions), nreg);
      check("R1 code steps", steps_bad, 0);
      check("R1 top code reached", top_seen, TOPC);
      @(negedge clk);
      check("R8 done one cycle", int'(done), 0);
      repeat (10) @(negedge clk);
      check("R8 chosen code held", int'(chosen_code), pick);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      fill(1'b1);
      repeat (3) @(negedge clk);
      check("R10 reset code", int'(delay_code), 0);
      check("R10 reset done", int'(done), 0);
      check("R10 reset chosen", int'(chosen_code), 0);
      check("R10 reset count", int'(unstable_regions), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: all codes stable, expect 319 and count 0
      fill(1'b1);
      sweep("R3 clean", 1'b0);

      // R9: nothing stable
      fill(1'b0);
      sweep("R9 all unstable", 1'b0);

      // R4 + R6: one region, lower run bounded by code 0 -> (0+500)/2 = 250
      fill(1'b1); mark_bad(500, 520);
      sweep("R4 R6 one region low edge", 1'b0);

      // R6: upper run bounded by the top code: bad 0..199 -> (199+639)/2 = 419
      fill(1'b1); mark_bad(0, 199);
      sweep("R6 top edge", 1'b0);

      // R5 tie: runs 30..329 and 340..639 both 300 long -> (29+330)/2 = 179
      fill(1'b1); mark_bad(20, 29); mark_bad(330, 339);
      sweep("R5 tie lowest", 1'b1);

      // R2: flickering border codes widen the unstable region
      fill(1'b1); mark_bad(300, 309);
      inter[298] = 1'b1; inter[299] = 1'b1; inter[310] = 1'b1;
      sweep("R2 flicker border", 1'b0);

      // R5: three regions with distinct runs
      fill(1'b1); mark_bad(100, 104); mark_bad(250, 251); mark_bad(600, 610);
      sweep("R5 three regions", 1'b0);

      for (int r = 0; r < 4; r++) begin
         int nr;
         fill(1'b1);
         nr = $urandom % 5;
         for (int j = 0; j < nr; j++) begin
            int lo, len;
            lo  = $urandom % (TOPC + 1);
            len = 1 + $urandom % 40;
            mark_bad(lo, lo + len - 1);
            if (lo > 0) inter[lo - 1] = 1'b1;
         end
         sweep("R4 R5 random", 1'b0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule